// File: doc/BRIEF.md
# UART Power-Mode Controller

This block wraps a one-byte-buffered 8N1 serial transmitter and receiver with handling for the chip's low-power states. A level `sleep_req` stands for the module clock being stopped. Any frame in progress in either direction is then dropped, and the line is parked high. The transmit buffer, the last received byte and the wake arming are kept. An always-on synchronizer watches the receive line during sleep. If wake-up was armed before sleep began and the module is enabled, a falling edge on that line produces a one-cycle wake interrupt.

A level `idle_req` stands for the CPU idling. With `stop_in_idle` low the UART keeps working. With it high, both engines freeze in their current state and resume from that state when idle ends. Leaving sleep clears the wake arming. After sleep the receiver first waits for the line to go high again, so the edge that caused the wake is not decoded as a start bit.

Top module: `uart_pm_ctrl`

## Requirements
- R1: After reset `tx` is 1, `tx_ready` is 1, and `rx_valid`, `rx_irq` and `wake_irq` are 0.
- R2: A byte written with `tx_load` while `tx_ready` is 1 goes into the buffer on that edge. The frame starts on the next edge while running: a start bit of 0, eight data bits with the LSB first, and a stop bit of 1, each held for CLKS_PER_BIT cycles. Frames are separated by at least one idle cycle.
- R3: While `sleep_req` is 1, `tx` is 1 and any frame in progress is dropped. A byte that is buffered but not yet started stays buffered (`tx_ready` stays 0) and is sent after sleep ends.
- R4: A reception cut by sleep is discarded: no `rx_valid` pulse, and `rx_data` keeps the previous byte.
- R5: If wake-up is armed and `mod_en` is 1, a falling edge on `rx` during sleep gives a one-cycle `wake_irq` pulse 3 clock edges after the edge is first sampled.
- R6: `wake_arm` sets the wake-up arming only while `sleep_req` is 0. The arming clears on the first edge after `sleep_req` falls, so a later sleep without re-arming gives no `wake_irq`.
- R7: With `mod_en` at 0, `tx` is held at 1, both engines are reset, and no `wake_irq` occurs.
- R8: With `rx_irq_sel` at 0, `rx_irq` pulses together with each `rx_valid`. With it at 1, `rx_irq` stays 0 for data. `wake_irq` behaves the same under both settings.
- R9: After sleep the receiver decodes no start bit until `rx` has been seen high.
- R10: With `idle_req` at 1 and `stop_in_idle` at 0, transmission and reception go on cycle for cycle as when not idle.
- R11: With `idle_req` at 1 and `stop_in_idle` at 1, `tx` holds its level. The frame resumes and completes from the same point, lengthened by the idle cycles.
- R12: A correctly framed byte (stop bit 1) appears on `rx_data` with a one-cycle `rx_valid`. `rx_data` holds that byte until the next one arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low reset |
| mod_en | input | 1 | Module enable |
| sleep_req | input | 1 | Sleep state level |
| idle_req | input | 1 | Idle state level |
| stop_in_idle | input | 1 | 1: freeze during idle |
| wake_arm | input | 1 | Pulse that arms wake-up on the receive line |
| rx_irq_sel | input | 1 | 1: no receive interrupt for data |
| tx_data | input | 8 | Byte to transmit |
| tx_load | input | 1 | Write `tx_data` to the transmit buffer |
| rx | input | 1 | Serial receive line (asynchronous) |
| tx | output | 1 | Serial transmit line |
| tx_ready | output | 1 | Transmit buffer empty |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle new-byte strobe |
| rx_irq | output | 1 | Receive interrupt pulse |
| wake_irq | output | 1 | Wake interrupt pulse |

## Verification
A transmitter state that is not cleared on sleep, or that is not frozen during idle, changes the level of `tx` within one bit period. The bench compares `tx` and `tx_ready` against its model on every clock, so the first wrong cycle is reported. A wrong synchronizer depth or wrong arming state shows as a `wake_irq` that comes early, late, is missing or is extra. It is caught in the cycle it occurs. Receiver faults, such as a partial frame kept through sleep or a missing wait-for-high, appear as an extra or corrupted `rx_valid` byte within one frame time.

// File: rtl/uart_pm_pkg.sv
package uart_pm_pkg;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_START = 2'd1,
        TX_DATA  = 2'd2,
        TX_STOP  = 2'd3
    } tx_st_e;

    typedef enum logic [2:0] {
        RX_ARM   = 3'd0,
        RX_IDLE  = 3'd1,
        RX_START = 3'd2,
        RX_DATA  = 3'd3,
        RX_STOP  = 3'd4
    } rx_st_e;

endpackage

// File: rtl/uart_pm_wake.sv
module uart_pm_wake (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    input  logic sleep_i,
    input  logic mod_en_i,
    input  logic arm_i,
    output logic rx_s_o,
    output logic wake_o
);

    typedef struct packed {
        logic m;
        logic s;
        logic p;
        logic slp;
        logic wen;
        logic wake;
    } wk_s_t;

    wk_s_t q, d;

    always_comb begin
        d      = q;
        d.m    = rx_i;
        d.s    = q.m;
        d.p    = q.s;
        d.slp  = sleep_i;
        if (q.slp && !sleep_i) begin
            d.wen = 1'b0;
        end else if (arm_i && !sleep_i) begin
            d.wen = 1'b1;
        end
        d.wake = sleep_i && q.wen && mod_en_i && q.p && !q.s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{m: 1'b1, s: 1'b1, p: 1'b1, slp: 1'b0, wen: 1'b0, wake: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign rx_s_o = q.s;
    assign wake_o = q.wake;

    a_r5_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);
    a_r5_wake_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> $past(sleep_i));
    a_r6_arm_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (q.slp && !sleep_i) |=> !q.wen);
    a_r7_no_wake_off: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en_i |=> !wake_o);

endmodule

// File: rtl/uart_pm_tx.sv
module uart_pm_tx
    import uart_pm_pkg::*;
#(
    parameter int CLKS_PER_BIT = 8,
    parameter int DATA_BITS    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run_i,
    input  logic                 abort_i,
    input  logic                 load_i,
    input  logic [DATA_BITS-1:0] data_i,
    output logic                 ready_o,
    output logic                 tx_o
);

    localparam int CNT_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLKS_PER_BIT - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_BITS - 1);

    typedef struct packed {
        tx_st_e               st;
        logic [CNT_W-1:0]     cnt;
        logic [IDX_W-1:0]     idx;
        logic [DATA_BITS-1:0] sh;
        logic [DATA_BITS-1:0] hold;
        logic                 full;
        logic                 line;
    } tx_s_t;

    tx_s_t q, d;
    logic  bit_end;

    assign bit_end = (q.cnt == CNT_LAST);

    always_comb begin
        d = q;
        if (load_i && !q.full) begin
            d.hold = data_i;
            d.full = 1'b1;
        end
        if (abort_i) begin
            d.st   = TX_IDLE;
            d.cnt  = '0;
            d.idx  = '0;
            d.line = 1'b1;
        end else if (run_i) begin
            case (q.st)
                TX_IDLE: begin
                    if (q.full) begin
                        d.st   = TX_START;
                        d.cnt  = '0;
                        d.sh   = q.hold;
                        d.full = 1'b0;
                        d.line = 1'b0;
                    end
                end
                TX_START: begin
                    if (bit_end) begin
                        d.cnt  = '0;
                        d.idx  = '0;
                        d.st   = TX_DATA;
                        d.line = q.sh[0];
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                TX_DATA: begin
                    if (bit_end) begin
                        d.cnt = '0;
                        d.sh  = q.sh >> 1;
                        if (q.idx == IDX_LAST) begin
                            d.st   = TX_STOP;
                            d.line = 1'b1;
                        end else begin
                            d.idx  = q.idx + 1'b1;
                            d.line = q.sh[1];
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                TX_STOP: begin
                    if (bit_end) begin
                        d.cnt = '0;
                        d.st  = TX_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                default: d.st = TX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: TX_IDLE, cnt: '0, idx: '0, sh: '0, hold: '0,
                   full: 1'b0, line: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign ready_o = !q.full;
    assign tx_o    = q.line;

    a_r3_line_high_abort: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> tx_o);
    a_r11_line_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !abort_i) |=> $stable(tx_o));
    a_r3_buffer_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i && !ready_o) |=> !ready_o);

endmodule

// File: rtl/uart_pm_rx.sv
module uart_pm_rx
    import uart_pm_pkg::*;
#(
    parameter int CLKS_PER_BIT = 8,
    parameter int DATA_BITS    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run_i,
    input  logic                 abort_i,
    input  logic                 rx_s_i,
    input  logic                 irq_sel_i,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 valid_o,
    output logic                 irq_o
);

    localparam int CNT_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLKS_PER_BIT - 1);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(CLKS_PER_BIT / 2 - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_BITS - 1);

    typedef struct packed {
        rx_st_e               st;
        logic [CNT_W-1:0]     cnt;
        logic [IDX_W-1:0]     idx;
        logic [DATA_BITS-1:0] sh;
        logic [DATA_BITS-1:0] data;
        logic                 valid;
        logic                 irq;
    } rx_s_t;

    rx_s_t q, d;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        d.irq   = 1'b0;
        if (abort_i) begin
            d.st  = RX_ARM;
            d.cnt = '0;
            d.idx = '0;
        end else if (run_i) begin
            case (q.st)
                RX_ARM: begin
                    if (rx_s_i) d.st = RX_IDLE;
                end
                RX_IDLE: begin
                    if (!rx_s_i) begin
                        d.st  = RX_START;
                        d.cnt = '0;
                    end
                end
                RX_START: begin
                    if (q.cnt == CNT_HALF) begin
                        d.cnt = '0;
                        d.idx = '0;
                        d.st  = rx_s_i ? RX_IDLE : RX_DATA;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (q.cnt == CNT_LAST) begin
                        d.cnt = '0;
                        d.sh  = {rx_s_i, q.sh[DATA_BITS-1:1]};
                        if (q.idx == IDX_LAST) d.st = RX_STOP;
                        else                   d.idx = q.idx + 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (q.cnt == CNT_LAST) begin
                        d.cnt = '0;
                        d.st  = RX_IDLE;
                        if (rx_s_i) begin
                            d.data  = q.sh;
                            d.valid = 1'b1;
                            d.irq   = !irq_sel_i;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                default: d.st = RX_ARM;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: RX_ARM, cnt: '0, idx: '0, sh: '0, data: '0,
                   valid: 1'b0, irq: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign data_o  = q.data;
    assign valid_o = q.valid;
    assign irq_o   = q.irq;

    a_r4_no_byte_abort: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> !valid_o);
    a_r12_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    a_r12_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(data_o));
    a_r8_irq_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> valid_o);

endmodule

// File: rtl/uart_pm_ctrl.sv
module uart_pm_ctrl #(
    parameter int CLKS_PER_BIT = 8,
    parameter int DATA_BITS    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mod_en,
    input  logic                 sleep_req,
    input  logic                 idle_req,
    input  logic                 stop_in_idle,
    input  logic                 wake_arm,
    input  logic                 rx_irq_sel,
    input  logic [DATA_BITS-1:0] tx_data,
    input  logic                 tx_load,
    input  logic                 rx,
    output logic                 tx,
    output logic                 tx_ready,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 rx_irq,
    output logic                 wake_irq
);

    logic run_c;
    logic abort_c;
    logic rx_s;

    assign abort_c = !mod_en || sleep_req;
    assign run_c   = !abort_c && !(idle_req && stop_in_idle);

    uart_pm_wake u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_i     (rx),
        .sleep_i  (sleep_req),
        .mod_en_i (mod_en),
        .arm_i    (wake_arm),
        .rx_s_o   (rx_s),
        .wake_o   (wake_irq)
    );

    uart_pm_tx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_BITS(DATA_BITS)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run_c),
        .abort_i (abort_c),
        .load_i  (tx_load),
        .data_i  (tx_data),
        .ready_o (tx_ready),
        .tx_o    (tx)
    );

    uart_pm_rx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_BITS(DATA_BITS)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_c),
        .abort_i   (abort_c),
        .rx_s_i    (rx_s),
        .irq_sel_i (rx_irq_sel),
        .data_o    (rx_data),
        .valid_o   (rx_valid),
        .irq_o     (rx_irq)
    );

    a_r7_tx_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en |=> tx);
    a_r3_tx_high_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |=> tx);

endmodule

// File: tb/tb_uart_pm_ctrl.sv
module tb_uart_pm_ctrl;

    localparam int CPB = 8;
    localparam int DB  = 8;
    localparam int FRAME = (DB + 2) * CPB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mod_en = 1'b1;
    logic          sleep_req = 1'b0;
    logic          idle_req = 1'b0;
    logic          stop_in_idle = 1'b0;
    logic          wake_arm = 1'b0;
    logic          rx_irq_sel = 1'b0;
    logic [DB-1:0] tx_data = '0;
    logic          tx_load = 1'b0;
    logic          rx = 1'b1;
    logic          tx;
    logic          tx_ready;
    logic [DB-1:0] rx_data;
    logic          rx_valid;
    logic          rx_irq;
    logic          wake_irq;

    int total = 0;
    int bad   = 0;
    int n_valid = 0;
    int n_rxirq = 0;
    int n_wake  = 0;
    logic [DB-1:0] last_byte = '0;
    bit finished = 0;

    always #2 clk = ~clk;

    uart_pm_ctrl #(.CLKS_PER_BIT(CPB), .DATA_BITS(DB)) dut (
        .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .sleep_req(sleep_req),
        .idle_req(idle_req), .stop_in_idle(stop_in_idle), .wake_arm(wake_arm),
        .rx_irq_sel(rx_irq_sel), .tx_data(tx_data), .tx_load(tx_load), .rx(rx),
        .tx(tx), .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_irq(rx_irq), .wake_irq(wake_irq)
    );

    // behavioural reference model
    int            m_pos = -1;
    bit            m_full = 0;
    logic [DB-1:0] m_hold = '0;
    logic [DB-1:0] m_byte = '0;
    bit            m_wen = 0;
    bit            m_slp = 0;
    bit            m_wake = 0;
    bit            h1 = 1, h2 = 1, h3 = 1;

    always @(posedge clk) begin
        if (rst_n) begin
            bit f0;
            bit run;
            bit abort;
            f0    = m_full;
            abort = !mod_en || sleep_req;
            run   = !abort && !(idle_req && stop_in_idle);
            if (tx_load && !f0) begin
                m_full = 1;
                m_hold = tx_data;
            end
            if (abort) begin
                m_pos = -1;
            end else if (run) begin
                if (m_pos >= 0) begin
                    if (m_pos == FRAME - 1) m_pos = -1;
                    else m_pos++;
                end else if (f0) begin
                    m_pos  = 0;
                    m_byte = m_hold;
                    m_full = 0;
                end
            end
            m_wake = sleep_req && m_wen && mod_en && h3 && !h2;
            if (m_slp && !sleep_req) m_wen = 0;
            else if (wake_arm && !sleep_req) m_wen = 1;
            m_slp = sleep_req;
            h3 = h2;
            h2 = h1;
            h1 = rx;
        end
    end

    function automatic logic exp_tx();
        if (m_pos < 0) return 1'b1;
        if (m_pos < CPB) return 1'b0;
        if (m_pos < (DB + 1) * CPB) return m_byte[m_pos / CPB - 1];
        return 1'b1;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison and event capture
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(tx == exp_tx(), "R2 R3 R10 R11 tx line", tx, exp_tx());
            check(tx_ready == !m_full, "R3 tx_ready", tx_ready, !m_full);
            check(wake_irq == m_wake, "R5 R6 R7 R8 wake_irq", wake_irq, m_wake);
            if (rx_valid) begin
                n_valid++;
                last_byte = rx_data;
            end
            if (rx_irq) n_rxirq++;
            if (wake_irq) n_wake++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_byte(input logic [DB-1:0] b);
        tx_data = b;
        tx_load = 1'b1;
        cyc(1);
        tx_load = 1'b0;
    endtask

    task automatic send_rx(input logic [DB-1:0] b);
        rx = 1'b0;
        cyc(CPB);
        for (int i = 0; i < DB; i++) begin
            rx = b[i];
            cyc(CPB);
        end
        rx = 1'b1;
        cyc(CPB);
    endtask

    task automatic pulse_arm();
        wake_arm = 1'b1;
        cyc(1);
        wake_arm = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v0, w0, q0;
        cyc(3);
        // R1 reset state
        check(tx == 1'b1, "R1 tx", tx, 1);
        check(tx_ready == 1'b1, "R1 tx_ready", tx_ready, 1);
        check({rx_valid, rx_irq, wake_irq} == 3'b000, "R1 pulses", {rx_valid, rx_irq, wake_irq}, 0);
        rst_n = 1'b1;
        cyc(2);

        // R2 plain frame
        load_byte(8'hA5);
        cyc(FRAME + 10);

        // R12 R8 receive with interrupt
        v0 = n_valid; q0 = n_rxirq;
        send_rx(8'h3C);
        cyc(4);
        check(n_valid == v0 + 1, "R12 byte count", n_valid, v0 + 1);
        check(last_byte == 8'h3C, "R12 rx_data", last_byte, 8'h3C);
        check(n_rxirq == q0 + 1, "R8 rx_irq sel0", n_rxirq, q0 + 1);
        cyc(10);
        check(rx_data == 8'h3C, "R12 data held", rx_data, 8'h3C);

        // R8 interrupt masked by select
        rx_irq_sel = 1'b1;
        v0 = n_valid; q0 = n_rxirq;
        send_rx(8'h81);
        cyc(4);
        check(n_valid == v0 + 1 && last_byte == 8'h81, "R8 byte sel1", last_byte, 8'h81);
        check(n_rxirq == q0, "R8 rx_irq sel1", n_rxirq, q0);
        rx_irq_sel = 1'b0;

        // R10 idle without stop, tx and rx keep running
        load_byte(8'h5A);
        cyc(30);
        idle_req = 1'b1;
        stop_in_idle = 1'b0;
        v0 = n_valid;
        send_rx(8'h96);
        cyc(4);
        check(n_valid == v0 + 1 && last_byte == 8'h96, "R10 rx in idle", last_byte, 8'h96);
        idle_req = 1'b0;
        cyc(FRAME);

        // R11 freeze in idle
        load_byte(8'hC3);
        cyc(25);
        idle_req = 1'b1;
        stop_in_idle = 1'b1;
        cyc(30);
        idle_req = 1'b0;
        stop_in_idle = 1'b0;
        cyc(FRAME + 10);

        // R3 sleep aborts tx, buffered byte kept
        load_byte(8'h11);
        cyc(20);
        load_byte(8'h22);
        cyc(5);
        sleep_req = 1'b1;
        cyc(40);
        check(tx == 1'b1, "R3 tx high in sleep", tx, 1);
        check(tx_ready == 1'b0, "R3 buffer kept", tx_ready, 0);
        sleep_req = 1'b0;
        cyc(FRAME + 10);

        // R4 sleep aborts rx
        v0 = n_valid;
        rx = 1'b0; cyc(CPB);
        rx = 1'b1; cyc(CPB);
        rx = 1'b0; cyc(CPB);
        sleep_req = 1'b1;
        rx = 1'b1;
        cyc(30);
        sleep_req = 1'b0;
        cyc(FRAME + 10);
        check(n_valid == v0, "R4 no byte", n_valid, v0);
        check(rx_data == 8'h96, "R4 rx_data kept", rx_data, 8'h96);

        // R5 wake, then R9 wait for high
        pulse_arm();
        sleep_req = 1'b1;
        cyc(10);
        w0 = n_wake;
        rx = 1'b0;
        cyc(10);
        check(n_wake == w0 + 1, "R5 one wake pulse", n_wake, w0 + 1);
        v0 = n_valid;
        sleep_req = 1'b0;
        cyc(30);
        rx = 1'b1;
        cyc(10);
        send_rx(8'h6E);
        cyc(FRAME);
        check(n_valid == v0 + 1, "R9 single byte", n_valid, v0 + 1);
        check(last_byte == 8'h6E, "R9 byte value", last_byte, 8'h6E);

        // R6 arming cleared at exit
        w0 = n_wake;
        sleep_req = 1'b1;
        cyc(5);
        rx = 1'b0;
        cyc(10);
        rx = 1'b1;
        sleep_req = 1'b0;
        cyc(5);
        check(n_wake == w0, "R6 cleared after exit", n_wake, w0);

        // R6 arming during sleep ignored
        sleep_req = 1'b1;
        cyc(3);
        pulse_arm();
        cyc(3);
        rx = 1'b0;
        cyc(10);
        rx = 1'b1;
        sleep_req = 1'b0;
        cyc(5);
        check(n_wake == w0, "R6 arm in sleep ignored", n_wake, w0);

        // R8 select has no effect on wake
        rx_irq_sel = 1'b1;
        pulse_arm();
        sleep_req = 1'b1;
        cyc(5);
        rx = 1'b0;
        cyc(10);
        check(n_wake == w0 + 1, "R8 wake with sel1", n_wake, w0 + 1);
        rx = 1'b1;
        sleep_req = 1'b0;
        rx_irq_sel = 1'b0;
        cyc(10);

        // R7 disabled module: no wake, tx high
        w0 = n_wake;
        mod_en = 1'b0;
        pulse_arm();
        sleep_req = 1'b1;
        cyc(5);
        rx = 1'b0;
        cyc(10);
        check(n_wake == w0, "R7 no wake when off", n_wake, w0);
        check(tx == 1'b1, "R7 tx high", tx, 1);
        rx = 1'b1;
        sleep_req = 1'b0;
        cyc(5);
        mod_en = 1'b1;
        cyc(10);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule